// File: doc/BRIEF.md
# Pipeline Exception Status Controller

This block follows the exception status of every instruction through a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and drives the control signals that keep exceptions precise. Fetch gives each instruction a status code from its instruction-memory error and decode-validity inputs. Decode and execute carry the code along unchanged. The memory stage can replace it when the data access fails. A status takes effect only when its instruction reaches write-back.

The surrounding core gives the block the fetched opcode, the fetch-side error flags, the data-memory error of the current memory-stage access and a flush request for a mispredicted branch. The block returns the architectural processor status and four enables. These are condition-code update, data-memory write, memory-stage bubble and write-back stall. All later instructions are stopped from changing condition codes or memory in the same cycle that an exception appears in the memory or write-back stage.

Top module: `pipe_exc_ctrl`

## Requirements
- R1: While reset is high, every pipeline status register holds the bubble code. The outputs then read stat_out = AOK with set_cc, dmem_we, m_bubble and w_stall all 0. The status codes are BUB=0, AOK=1, HLT=2, ADR=3, INS=4.
- R2: Fetch classifies an instruction in this order. It is ADR when imem_err=1, else INS when instr_valid=0, else HLT when the opcode equals HALT_OP (1), else AOK.
- R3: The status of an instruction fetched in cycle t appears on stat_out in cycle t+4, unchanged by the decode and execute stages.
- R4: The memory stage turns an AOK status into ADR when dmem_err=1. dmem_err has no effect on a bubble or on an instruction that already carries HLT, ADR or INS.
- R5: set_cc is 1 only when all of these hold: the execute-stage opcode is ALU_OP (6), its status is AOK, and neither the memory-stage status (after R4) nor the write-back status is HLT, ADR or INS.
- R6: m_bubble is 1 whenever the memory-stage status or the write-back status is HLT, ADR or INS. The memory stage then holds a bubble in the next cycle, so no later instruction ever writes data memory.
- R7: dmem_we is 1 only for a memory-stage opcode of STORE_OP (4) whose memory-stage status is AOK after R4, and only while write-back holds no exception.
- R8: While write-back holds HLT, ADR or INS, w_stall is 1 and write-back keeps that instruction. stat_out then keeps the exception code until reset.
- R9: When several instructions raise exceptions, only the one furthest along the pipeline is reported.
- R10: An instruction classified INS or ADR at fetch acts as a bubble for control: it never sets set_cc or dmem_we, whatever its opcode. It still carries its status to write-back.
- R11: br_flush=1 in a cycle loads the bubble code into the decode and execute stages at the next edge. The squashed instructions never raise their exceptions.
- R12: stat_out reads AOK while write-back holds a bubble, and the write-back status otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_err | input | 1 | Instruction-memory access error for the fetched instruction |
| instr_valid | input | 1 | Fetched instruction decodes to a legal opcode |
| f_opcode | input | OPW | Opcode of the fetched instruction |
| dmem_err | input | 1 | Data-memory access error of the memory-stage instruction, this cycle |
| br_flush | input | 1 | Squash decode and execute (branch mispredicted) |
| stat_out | output | 3 | Architectural processor status |
| set_cc | output | 1 | Condition codes may be written this cycle |
| dmem_we | output | 1 | Data-memory write enable |
| m_bubble | output | 1 | Bubble is injected into the memory stage at the next edge |
| w_stall | output | 1 | Write-back register holds its instruction |

## Verification
An instruction fetched in bench cycle t is in execute at t+2, so its set_cc is due in that cycle. It is in the memory stage at t+3, where its dmem_we and m_bubble are due and where the bench drives its dmem_err. Its status reaches stat_out at t+4. The driver stores each expected value with its due cycle worked out from these offsets. The monitor compares it in exactly that cycle, two nanoseconds after the falling edge at which inputs change, and any expectation left unmatched counts as a failure.

// File: rtl/pes_pkg.sv
package pes_pkg;

    typedef enum logic [2:0] {
        ST_BUB = 3'd0,
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } stat_e;

    // True for the codes that stop the machine
    function automatic logic is_exc(stat_e s);
        return (s == ST_ADR) || (s == ST_INS) || (s == ST_HLT);
    endfunction

endpackage

// File: rtl/pes_fetch_class.sv
module pes_fetch_class
    import pes_pkg::*;
#(
    parameter int              OPW     = 4,
    parameter logic [OPW-1:0]  NOP_OP  = '0,
    parameter logic [OPW-1:0]  HALT_OP = 1
) (
    input  logic           imem_err,
    input  logic           instr_valid,
    input  logic [OPW-1:0] f_opcode,
    output stat_e          f_stat,
    output logic [OPW-1:0] f_op_eff
);

    always_comb begin
        if (imem_err)                f_stat = ST_ADR;
        else if (!instr_valid)       f_stat = ST_INS;
        else if (f_opcode == HALT_OP) f_stat = ST_HLT;
        else                         f_stat = ST_AOK;
        // Faulted fetches travel with a no-op opcode so they act as bubbles
        f_op_eff = ((f_stat == ST_AOK) || (f_stat == ST_HLT)) ? f_opcode : NOP_OP;
    end

endmodule

// File: rtl/pes_stage_chain.sv
module pes_stage_chain
    import pes_pkg::*;
#(
    parameter int              OPW    = 4,
    parameter logic [OPW-1:0]  NOP_OP = '0,
    parameter int              MID    = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  stat_e          f_stat,
    input  logic [OPW-1:0] f_op,
    input  logic           flush,
    input  logic           m_bubble,
    input  logic           w_stall,
    input  logic           dmem_err,
    output stat_e          e_stat,
    output logic [OPW-1:0] e_op,
    output stat_e          m_stat,
    output logic [OPW-1:0] m_op,
    output stat_e          w_stat
);

    typedef struct packed {
        stat_e          st;
        logic [OPW-1:0] op;
    } slot_t;

    typedef struct packed {
        slot_t [MID-1:0] mid;
        slot_t           mem;
        stat_e           wb;
    } chain_t;

    localparam slot_t BUB_SLOT = '{st: ST_BUB, op: NOP_OP};

    chain_t pipe_d, pipe_q;
    stat_e  m_eff;

    always_comb begin
        m_eff = (pipe_q.mem.st == ST_AOK && dmem_err) ? ST_ADR : pipe_q.mem.st;
    end

    always_comb begin
        pipe_d = pipe_q;
        for (int i = 0; i < MID; i++) begin
            if (flush)       pipe_d.mid[i] = BUB_SLOT;
            else if (i == 0) pipe_d.mid[i] = '{st: f_stat, op: f_op};
            else             pipe_d.mid[i] = pipe_q.mid[i-1];
        end
        pipe_d.mem = m_bubble ? BUB_SLOT : pipe_q.mid[MID-1];
        pipe_d.wb  = w_stall ? pipe_q.wb : m_eff;
        if (rst) begin
            for (int i = 0; i < MID; i++) pipe_d.mid[i] = BUB_SLOT;
            pipe_d.mem = BUB_SLOT;
            pipe_d.wb  = ST_BUB;
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign e_stat = pipe_q.mid[MID-1].st;
    assign e_op   = pipe_q.mid[MID-1].op;
    assign m_stat = m_eff;
    assign m_op   = pipe_q.mem.op;
    assign w_stat = pipe_q.wb;

    // R6: a requested bubble is what the memory stage holds next
    a_r6_mem_squashed: assert property (@(posedge clk) disable iff (rst)
        m_bubble |=> (pipe_q.mem.st == ST_BUB));

    // R8: a stalled write-back register keeps its content
    a_r8_wb_frozen: assert property (@(posedge clk) disable iff (rst)
        w_stall |=> $stable(pipe_q.wb));

    generate
        for (genvar g = 0; g < MID; g++) begin : g_flush_chk
            // R11: flushed front stages come back as bubbles
            a_r11_flush_bub: assert property (@(posedge clk) disable iff (rst)
                flush |=> (pipe_q.mid[g].st == ST_BUB));
        end
    endgenerate

endmodule

// File: rtl/pes_hazard_ctrl.sv
module pes_hazard_ctrl
    import pes_pkg::*;
#(
    parameter int              OPW      = 4,
    parameter logic [OPW-1:0]  ALU_OP   = 6,
    parameter logic [OPW-1:0]  STORE_OP = 4
) (
    input  stat_e          e_stat,
    input  logic [OPW-1:0] e_op,
    input  stat_e          m_stat,
    input  logic [OPW-1:0] m_op,
    input  stat_e          w_stat,
    output logic           set_cc,
    output logic           dmem_we,
    output logic           m_bubble,
    output logic           w_stall
);

    logic late_exc;

    always_comb begin
        late_exc = is_exc(m_stat) || is_exc(w_stat);
        set_cc   = (e_op == ALU_OP) && (e_stat == ST_AOK) && !late_exc;
        m_bubble = late_exc;
        w_stall  = is_exc(w_stat);
        dmem_we  = (m_op == STORE_OP) && (m_stat == ST_AOK) && !is_exc(w_stat);
    end

endmodule

// File: rtl/pes_status_report.sv
module pes_status_report
    import pes_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_e w_stat,
    output stat_e stat_out
);

    always_comb begin
        stat_out = (w_stat == ST_BUB) ? ST_AOK : w_stat;
    end

    // R8: a reported exception stays on the output
    a_r8_report_hold: assert property (@(posedge clk) disable iff (rst)
        is_exc(stat_out) |=> (stat_out == $past(stat_out)));

endmodule

// File: rtl/pipe_exc_ctrl.sv
module pipe_exc_ctrl
    import pes_pkg::*;
#(
    parameter int              OPW      = 4,
    parameter logic [OPW-1:0]  NOP_OP   = 0,
    parameter logic [OPW-1:0]  HALT_OP  = 1,
    parameter logic [OPW-1:0]  STORE_OP = 4,
    parameter logic [OPW-1:0]  ALU_OP   = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           imem_err,
    input  logic           instr_valid,
    input  logic [OPW-1:0] f_opcode,
    input  logic           dmem_err,
    input  logic           br_flush,
    output logic [2:0]     stat_out,
    output logic           set_cc,
    output logic           dmem_we,
    output logic           m_bubble,
    output logic           w_stall
);

    localparam int MID_STAGES = 2;

    stat_e          f_stat, e_stat, m_stat, w_stat, rep_stat;
    logic [OPW-1:0] f_op, e_op, m_op;

    pes_fetch_class #(.OPW(OPW), .NOP_OP(NOP_OP), .HALT_OP(HALT_OP)) u_fetch (
        .imem_err    (imem_err),
        .instr_valid (instr_valid),
        .f_opcode    (f_opcode),
        .f_stat      (f_stat),
        .f_op_eff    (f_op)
    );

    pes_stage_chain #(.OPW(OPW), .NOP_OP(NOP_OP), .MID(MID_STAGES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .f_stat   (f_stat),
        .f_op     (f_op),
        .flush    (br_flush),
        .m_bubble (m_bubble),
        .w_stall  (w_stall),
        .dmem_err (dmem_err),
        .e_stat   (e_stat),
        .e_op     (e_op),
        .m_stat   (m_stat),
        .m_op     (m_op),
        .w_stat   (w_stat)
    );

    pes_hazard_ctrl #(.OPW(OPW), .ALU_OP(ALU_OP), .STORE_OP(STORE_OP)) u_ctrl (
        .e_stat   (e_stat),
        .e_op     (e_op),
        .m_stat   (m_stat),
        .m_op     (m_op),
        .w_stat   (w_stat),
        .set_cc   (set_cc),
        .dmem_we  (dmem_we),
        .m_bubble (m_bubble),
        .w_stall  (w_stall)
    );

    pes_status_report u_report (
        .clk      (clk),
        .rst      (rst),
        .w_stat   (w_stat),
        .stat_out (rep_stat)
    );

    assign stat_out = rep_stat;

    // R7: no memory write in a cycle that squashes the memory stage
    a_r7_no_write_on_squash: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !m_bubble);

endmodule

// File: tb/pipe_exc_ctrl_test.sv
module pipe_exc_ctrl_test;

    localparam int       OPW  = 4;
    localparam bit [3:0] NOP  = 4'd0;
    localparam bit [3:0] HALT = 4'd1;
    localparam bit [3:0] STO  = 4'd4;
    localparam bit [3:0] ALU  = 4'd6;
    localparam int AOK = 1, HLT = 2, ADR = 3, INS = 4;
    localparam int S_STAT = 0, S_CC = 1, S_WE = 2, S_MB = 3, S_WS = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst = 1'b1;
    logic           imem_err = 1'b0, instr_valid = 1'b1, dmem_err = 1'b0, br_flush = 1'b0;
    logic [OPW-1:0] f_opcode = NOP;
    logic [2:0]     stat_out;
    logic           set_cc, dmem_we, m_bubble, w_stall;

    pipe_exc_ctrl uut (
        .clk(clk), .rst(rst), .imem_err(imem_err), .instr_valid(instr_valid),
        .f_opcode(f_opcode), .dmem_err(dmem_err), .br_flush(br_flush),
        .stat_out(stat_out), .set_cc(set_cc), .dmem_we(dmem_we),
        .m_bubble(m_bubble), .w_stall(w_stall)
    );

    typedef struct {
        int    due;
        int    sig;
        int    val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   tnow = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int read_sig(int s);
        case (s)
            S_STAT:  return int'(stat_out);
            S_CC:    return int'(set_cc);
            S_WE:    return int'(dmem_we);
            S_MB:    return int'(m_bubble);
            default: return int'(w_stall);
        endcase
    endfunction

    task automatic expect_at(int off, int sig, int val, string tag);
        exp_t e;
        e.due = tnow + off; e.sig = sig; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares due expectations away from both clock edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    n_chk++;
                    if (read_sig(q[i].sig) != q[i].val) begin
                        n_fail++;
                        $display("FAIL %s cycle %0d signal %0d actual %0d expected %0d",
                                 q[i].tag, cyc, q[i].sig, read_sig(q[i].sig), q[i].val);
                    end
                    q.delete(i);
                end
            end
        end
    end

    task automatic drive(bit ie, bit v, bit [3:0] op, bit de, bit fl);
        @(negedge clk);
        tnow        = cyc;
        imem_err    = ie;
        instr_valid = v;
        f_opcode    = op;
        dmem_err    = de;
        br_flush    = fl;
    endtask

    task automatic idle(int n);
        repeat (n) drive(1'b0, 1'b1, NOP, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        imem_err = 0; instr_valid = 1; f_opcode = NOP; dmem_err = 0; br_flush = 0;
        @(negedge clk);
        tnow = cyc;
        // R1: reset state
        expect_at(0, S_STAT, AOK, "R1");
        expect_at(0, S_CC, 0, "R1");
        expect_at(0, S_WE, 0, "R1");
        expect_at(0, S_MB, 0, "R1");
        expect_at(0, S_WS, 0, "R1");
        @(negedge clk);
        tnow = cyc;
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Scenario A: normal ALU and store
        do_reset();
        drive(0, 1, ALU, 0, 0);
        expect_at(2, S_CC, 1, "R5");
        expect_at(4, S_STAT, AOK, "R3");
        expect_at(4, S_WS, 0, "R12");
        drive(0, 1, STO, 0, 0);
        expect_at(2, S_CC, 0, "R5");
        expect_at(3, S_WE, 1, "R7");
        expect_at(3, S_MB, 0, "R6");
        idle(8);

        // Scenario B: fetch error wins over the others, then held
        do_reset();
        drive(1, 0, HALT, 0, 0);
        expect_at(3, S_MB, 1, "R6");
        expect_at(4, S_STAT, ADR, "R2");
        expect_at(4, S_WS, 1, "R8");
        expect_at(9, S_STAT, ADR, "R8");
        expect_at(9, S_WS, 1, "R8");
        idle(11);

        // Scenario C: invalid wins over halt
        do_reset();
        drive(0, 0, HALT, 0, 0);
        expect_at(3, S_STAT, AOK, "R3");
        expect_at(4, S_STAT, INS, "R2");
        idle(8);

        // Scenario D: halt blocks a following ALU op
        do_reset();
        drive(0, 1, HALT, 0, 0);
        expect_at(4, S_STAT, HLT, "R2");
        drive(0, 1, ALU, 0, 0);
        expect_at(2, S_CC, 0, "R5");
        idle(8);

        // Scenario E: data error on store, later exceptions hidden
        do_reset();
        drive(0, 1, STO, 0, 0);
        expect_at(3, S_WE, 0, "R7");
        expect_at(3, S_MB, 1, "R4");
        expect_at(4, S_STAT, ADR, "R4");
        expect_at(4, S_MB, 1, "R6");
        expect_at(7, S_STAT, ADR, "R9");
        expect_at(8, S_STAT, ADR, "R9");
        drive(0, 0, NOP, 0, 0);
        drive(0, 1, ALU, 0, 0);
        expect_at(2, S_CC, 0, "R5");
        drive(0, 1, STO, 1, 0);
        expect_at(3, S_WE, 0, "R6");
        idle(10);

        // Scenario F: data error ignored on bubble and on INS
        do_reset();
        drive(0, 0, NOP, 1, 0);
        expect_at(0, S_MB, 0, "R4");
        expect_at(1, S_STAT, AOK, "R12");
        idle(2);
        drive(0, 1, NOP, 1, 0);
        expect_at(1, S_STAT, INS, "R4");
        idle(8);

        // Scenario G: branch flush squashes pending exceptions
        do_reset();
        drive(0, 1, ALU, 0, 0);
        expect_at(2, S_CC, 1, "R11");
        drive(0, 0, NOP, 0, 0);
        expect_at(4, S_STAT, AOK, "R11");
        drive(0, 1, HALT, 0, 1);
        expect_at(4, S_STAT, AOK, "R11");
        expect_at(4, S_WS, 0, "R11");
        expect_at(6, S_STAT, AOK, "R11");
        idle(9);

        // Scenario H: illegal instruction is a bubble for control
        do_reset();
        drive(0, 0, ALU, 0, 0);
        expect_at(2, S_CC, 0, "R10");
        expect_at(4, S_STAT, INS, "R10");
        idle(8);
        do_reset();
        drive(0, 0, STO, 0, 0);
        expect_at(3, S_WE, 0, "R10");
        expect_at(3, S_MB, 1, "R10");
        idle(8);

        do_reset();
        idle(3);

        if (q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL unmatched expectations actual %0d expected 0", q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule